// File: doc/BRIEF.md
# Two-Sector Instruction Cache with Least-Recently-Used Replacement

This block sits between the fetch stage of a signal-processing core and its program memory. It keeps two sectors of 32 instruction words. Each sector covers one aligned run of 32 consecutive program addresses. A fetch that lands inside a sector it already holds is answered from the sector storage in the same cycle. The program memory port stays idle for that fetch.

A fetch outside both held runs is a miss. On a miss the whole least recently used sector is thrown away and pointed at the new run. It is then refilled one word at a time from program memory, lowest address first. The fetch waits only until its own word comes back. That word is passed straight through while the rest of the sector keeps filling.

A disable input sends every fetch directly to program memory. While it is high, nothing is allocated and no hit is served.

Top module: `sector_icache`

## Requirements
- R1: After reset every sector is empty: `fetch_ready` and `mem_req` are low, and the first fetch of any address produces a program memory request.
- R2: A miss refills the chosen sector with exactly 32 requests at addresses base, base+1 … base+31, one request per returned word. Afterwards every word of that run is returned correctly with no further request.
- R3: A fetch whose word is held and valid gets `fetch_ready` high in the same cycle that `fetch_req` is presented. No memory request is made, and `fetch_ready` is never high without `fetch_req`.
- R4: During a fill, the requested word is returned in the cycle its `mem_valid` arrives, before the rest of the sector is filled.
- R5: On a miss, the sector replaced is the one not used most recently, so the other sector's contents stay hit-able.
- R6: Every served hit, and every allocation, marks the sector just used as most recent.
- R7: With `cache_off` high, each fetch makes exactly one memory request at the fetch address and returns that data. Hits are not served, and no sector is allocated or changed.
- R8: A sector's base address is the fetch address with its low 5 bits cleared (tag = address >> 5). A miss at offset k is answered on the (k+1)-th request of that fill.
- R9: A fetch to a third run while a fill is in progress stalls until the fill has completed, then proceeds as a miss.
- R10: At most one program memory request is outstanding: `mem_req` is never raised again before the matching `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_off | input | 1 | High: route every fetch to program memory, no allocation |
| fetch_req | input | 1 | Fetch request, held with its address until `fetch_ready` |
| fetch_addr | input | 16 | Program word address of the fetch |
| fetch_ready | output | 1 | Fetch completes this cycle; `fetch_data` is valid |
| fetch_data | output | 16 | Instruction word returned to the core |
| mem_req | output | 1 | One-cycle read request to program memory |
| mem_addr | output | 16 | Word address of the read request |
| mem_valid | input | 1 | One-cycle pulse: `mem_data` answers the outstanding request |
| mem_data | input | 16 | Read data from program memory |

## Verification
The bench counts program memory requests between the start of each fetch and its completion. A design that waited for the full fill before answering would show 32 requests where one (or k+1 at offset k) is expected. A design that re-fetched on hits would show nonzero counts on resident words. Replacement order is tested by touching one sector between two misses: without LRU the wrong sector is evicted, and a later fetch of the kept run issues requests. Disable is tested on a resident run and on a new run. A design that allocated while disabled would then hit the new run instead of missing. A cross-run fetch during a fill checks that the fill is neither abandoned nor interleaved, which would change the request total.

// File: rtl/icache_pkg.sv
package icache_pkg;

    parameter int ADDR_W     = 16;
    parameter int DATA_W     = 16;
    parameter int SECT_WORDS = 32;
    parameter int NSECT      = 2;

    localparam int OFF_W  = $clog2(SECT_WORDS);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int SEL_W  = (NSECT > 1) ? $clog2(NSECT) : 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_BYPASS = 2'd2
    } ctl_state_e;

    // result of looking up one sector
    typedef struct packed {
        logic  hit;     // sector valid and tag matches
        logic  wvalid;  // addressed word already present
        word_t data;
    } lookup_t;

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(input addr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic addr_t join_addr(input tag_t t, input off_t o);
        return {t, o};
    endfunction

endpackage

// File: rtl/icache_sector.sv
module icache_sector
    import icache_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    alloc,
    input  tag_t    alloc_tag,
    input  logic    wr_en,
    input  off_t    wr_off,
    input  word_t   wr_data,
    input  addr_t   lk_addr,
    output lookup_t lk
);

    tag_t                  tag_q;
    logic                  sv_q;
    logic [SECT_WORDS-1:0] wv_q;
    word_t                 store_q [SECT_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            sv_q  <= 1'b0;
            wv_q  <= '0;
        end else if (alloc) begin
            tag_q <= alloc_tag;
            sv_q  <= 1'b1;
            wv_q  <= '0;
        end else if (wr_en) begin
            wv_q[wr_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !alloc) begin
            store_q[wr_off] <= wr_data;
        end
    end

    always_comb begin
        lk.hit    = sv_q && (tag_q == tag_of(lk_addr));
        lk.wvalid = wv_q[off_of(lk_addr)];
        lk.data   = store_q[off_of(lk_addr)];
    end

    // R1
    word_valid_needs_sector_chk: assert property (@(posedge clk) disable iff (rst)
        (|wv_q) |-> sv_q);

    // R2
    alloc_clears_words_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |=> (wv_q == '0));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cache_off,
    input  logic                  fetch_req,
    input  addr_t                 fetch_addr,
    input  lookup_t [NSECT-1:0]   lk,
    input  logic                  mem_valid,
    input  word_t                 mem_data,
    output logic                  fetch_ready,
    output word_t                 fetch_data,
    output logic                  mem_req,
    output addr_t                 mem_addr,
    output logic [NSECT-1:0]      alloc,
    output tag_t                  alloc_tag,
    output logic [NSECT-1:0]      wr_en,
    output off_t                  wr_off,
    output word_t                 wr_data
);

    localparam off_t LAST_OFF = off_t'(SECT_WORDS - 1);

    ctl_state_e st_q;
    sel_t       lru_q;       // next victim
    sel_t       fill_sect_q;
    tag_t       fill_tag_q;
    off_t       fill_ptr_q;
    logic       mem_req_q;
    addr_t      mem_addr_q;
    logic       outstanding_q;

    logic tag_hit_any;
    sel_t sel;
    logic serve_hit, forward, bypass_done, alloc_go, byp_go;

    always_comb begin
        tag_hit_any = 1'b0;
        sel         = '0;
        for (int i = 0; i < NSECT; i++) begin
            if (lk[i].hit) begin
                tag_hit_any = 1'b1;
                sel         = sel_t'(i);
            end
        end
    end

    assign serve_hit   = fetch_req && !cache_off && (st_q != ST_BYPASS)
                         && lk[sel].hit && lk[sel].wvalid;
    assign forward     = fetch_req && !cache_off && (st_q == ST_FILL) && mem_valid
                         && (fill_tag_q == tag_of(fetch_addr))
                         && (fill_ptr_q == off_of(fetch_addr));
    assign bypass_done = (st_q == ST_BYPASS) && mem_valid;
    assign alloc_go    = (st_q == ST_IDLE) && fetch_req && !cache_off && !tag_hit_any;
    assign byp_go      = (st_q == ST_IDLE) && fetch_req && cache_off;

    assign fetch_ready = serve_hit || forward || bypass_done;
    assign fetch_data  = (forward || bypass_done) ? mem_data : lk[sel].data;

    assign mem_req   = mem_req_q;
    assign mem_addr  = mem_addr_q;
    assign alloc_tag = tag_of(fetch_addr);
    assign wr_off    = fill_ptr_q;
    assign wr_data   = mem_data;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect_ctl
        assign alloc[g] = alloc_go && (lru_q == sel_t'(g));
        assign wr_en[g] = (st_q == ST_FILL) && mem_valid && (fill_sect_q == sel_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            fill_sect_q <= '0;
            fill_tag_q  <= '0;
            fill_ptr_q  <= '0;
            mem_req_q   <= 1'b0;
            mem_addr_q  <= '0;
        end else begin
            mem_req_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (alloc_go) begin
                        fill_sect_q <= lru_q;
                        fill_tag_q  <= tag_of(fetch_addr);
                        fill_ptr_q  <= '0;
                        mem_req_q   <= 1'b1;
                        mem_addr_q  <= join_addr(tag_of(fetch_addr), '0);
                        st_q        <= ST_FILL;
                    end else if (byp_go) begin
                        mem_req_q  <= 1'b1;
                        mem_addr_q <= fetch_addr;
                        st_q       <= ST_BYPASS;
                    end
                end
                ST_FILL: begin
                    if (mem_valid) begin
                        if (fill_ptr_q == LAST_OFF) begin
                            st_q <= ST_IDLE;
                        end else begin
                            fill_ptr_q <= fill_ptr_q + 1'b1;
                            mem_req_q  <= 1'b1;
                            mem_addr_q <= join_addr(fill_tag_q, fill_ptr_q + 1'b1);
                        end
                    end
                end
                ST_BYPASS: begin
                    if (mem_valid) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // replacement order
    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (alloc_go) begin
            lru_q <= ~lru_q;
        end else if (serve_hit) begin
            lru_q <= ~sel;
        end else if (forward) begin
            lru_q <= ~fill_sect_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            outstanding_q <= 1'b0;
        else if (mem_req_q) outstanding_q <= 1'b1;
        else if (mem_valid) outstanding_q <= 1'b0;
    end

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        outstanding_q |-> !mem_req);

    // R3
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ready |-> fetch_req);

    // R2
    fill_ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FILL && mem_valid && fill_ptr_q != LAST_OFF)
        |=> (mem_req && off_of(mem_addr) == off_t'($past(fill_ptr_q) + 1'b1)));

    // R6
    hit_moves_lru_chk: assert property (@(posedge clk) disable iff (rst)
        serve_hit |=> (lru_q != $past(sel)));

    // R7
    off_goes_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && cache_off && fetch_req) |=> (st_q == ST_BYPASS && mem_req));

endmodule

// File: rtl/sector_icache.sv
module sector_icache
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_off,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data
);

    lookup_t [NSECT-1:0] lk;
    logic    [NSECT-1:0] alloc;
    logic    [NSECT-1:0] wr_en;
    tag_t                alloc_tag;
    off_t                wr_off;
    word_t               wr_data;

    for (genvar g = 0; g < NSECT; g++) begin : g_sector
        icache_sector u_sector (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc[g]),
            .alloc_tag (alloc_tag),
            .wr_en     (wr_en[g]),
            .wr_off    (wr_off),
            .wr_data   (wr_data),
            .lk_addr   (fetch_addr),
            .lk        (lk[g])
        );
    end

    icache_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cache_off   (cache_off),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .lk          (lk),
        .mem_valid   (mem_valid),
        .mem_data    (mem_data),
        .fetch_ready (fetch_ready),
        .fetch_data  (fetch_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .alloc       (alloc),
        .alloc_tag   (alloc_tag),
        .wr_en       (wr_en),
        .wr_off      (wr_off),
        .wr_data     (wr_data)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!mem_req && !fetch_ready));

endmodule

// File: tb/sim_sector_icache.sv
`timescale 1ns/1ps
module sim_sector_icache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_off = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ready;
    logic [15:0] fetch_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    sector_icache u0 (
        .clk(clk), .rst(rst), .cache_off(cache_off),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [15:0] pm_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    // program memory model: answers each request two edges later
    int          req_cnt = 0;
    logic [15:0] req_log [0:255];
    int          lat_cnt = 0;
    logic [15:0] pend_addr = '0;

    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                mem_valid <= 1'b1;
                mem_data  <= pm_word(pend_addr);
            end
        end
        if (mem_req) begin
            lat_cnt   <= 2;
            pend_addr <= mem_addr;
            req_log[req_cnt % 256] <= mem_addr;
            req_cnt   <= req_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [15:0] a, output logic [15:0] d,
                            output int cyc, output int reqs);
        int r0;
        @(negedge clk);
        r0 = req_cnt;
        fetch_req  = 1'b1;
        fetch_addr = a;
        #1;
        cyc = 0;
        while (!fetch_ready && cyc < 1000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        d    = fetch_data;
        reqs = req_cnt - r0;
        if (cyc >= 1000) check(1'b0, "fetch hang", cyc, 0);
        @(posedge clk);
        #1;
        fetch_req = 1'b0;
    endtask

    task automatic settle();
        repeat (160) @(negedge clk);
    endtask

    // expect a resident word: same-cycle ready, no memory traffic
    task automatic expect_hit(input logic [15:0] a, input string req);
        logic [15:0] d; int c, r;
        do_fetch(a, d, c, r);
        check(d == pm_word(a), {req, " data"}, d, pm_word(a));
        check(c == 0 && r == 0, {req, " hit no stall/no request"}, c * 1000 + r, 0);
    endtask

    task automatic expect_miss(input logic [15:0] a, input string req);
        logic [15:0] d; int c, r;
        do_fetch(a, d, c, r);
        check(d == pm_word(a), {req, " data"}, d, pm_word(a));
        check(r == int'(a[4:0]) + 1, {req, " miss forwarded at own word"}, r, a[4:0] + 1);
        settle();
    endtask

    task automatic t_reset();
        logic [15:0] d; int c, r; int base;
        // R1: idle outputs after reset
        check(fetch_ready == 1'b0, "R1 ready low after reset", fetch_ready, 0);
        check(mem_req == 1'b0, "R1 mem_req low after reset", mem_req, 0);
        base = req_cnt;
        // R1 R4: first fetch misses and is answered on the first returned word
        do_fetch(16'h0100, d, c, r);
        check(r == 1, "R4 forward on first word", r, 1);
        check(d == pm_word(16'h0100), "R1 first fetch data", d, pm_word(16'h0100));
        // R9: other run while filling waits for whole fill
        do_fetch(16'h0240, d, c, r);
        check(req_cnt - base == 33, "R9 stall until fill done", req_cnt - base, 33);
        check(d == pm_word(16'h0240), "R9 data after stall", d, pm_word(16'h0240));
        settle();
        // R2: fill order from base upward
        for (int i = 0; i < 32; i++) begin
            check(req_log[(base + i) % 256] == 16'h0100 + 16'(i), "R2 fill order",
                  req_log[(base + i) % 256], 16'h0100 + i);
        end
        check(req_cnt - base == 64, "R2 32 requests per fill", req_cnt - base, 64);
    endtask

    task automatic t_hits();
        // R2 R3: every word of both runs resident
        for (int i = 0; i < 32; i++) expect_hit(16'h0100 + 16'(i), "R3");
        for (int i = 31; i >= 0; i--) expect_hit(16'h0240 - 16'h0040 + 16'h0040 + 16'(i) - 16'h0000 + 16'h0000 - (16'h0240 & 16'h001F) + 16'h0000, "R2");
    endtask

    task automatic t_lru();
        logic [15:0] d; int c, r;
        // sectors hold 0x0100 and 0x0240; touch 0x0100, then miss 0x0400
        expect_hit(16'h0105, "R6");
        expect_miss(16'h0400, "R5");
        // R5: 0x0100 kept, 0x0240 evicted
        expect_hit(16'h0110, "R5 kept sector");
        // now touch 0x0100 again; next miss must evict 0x0400
        expect_miss(16'h0243, "R5 evicted run refetched");
        // R6: 0x0100 was touched last among survivors? check it survives
        expect_hit(16'h011F, "R6 hit kept sector");
        do_fetch(16'h0401, d, c, r);
        check(r > 0, "R6 replaced run misses", r, 1);
        settle();
    endtask

    task automatic t_offset();
        int base;
        base = req_cnt;
        // R8: offset 23 miss, base aligned, answered on 24th request
        expect_miss(16'h0517, "R8");
        check(req_log[base % 256] == 16'h0500, "R8 fill starts at base",
              req_log[base % 256], 16'h0500);
        expect_hit(16'h0500, "R8 base word");
    endtask

    task automatic t_disable();
        logic [15:0] d; int c, r;
        cache_off = 1'b1;
        // R7: resident word still goes to memory
        do_fetch(16'h0503, d, c, r);
        check(r == 1, "R7 one request when off", r, 1);
        check(req_log[(req_cnt - 1) % 256] == 16'h0503, "R7 request address",
              req_log[(req_cnt - 1) % 256], 16'h0503);
        check(d == pm_word(16'h0503), "R7 data when off", d, pm_word(16'h0503));
        do_fetch(16'h0620, d, c, r);
        check(r == 1 && d == pm_word(16'h0620), "R7 new run when off", r, 1);
        repeat (4) @(negedge clk);
        cache_off = 1'b0;
        // R7: nothing allocated, nothing disturbed
        expect_hit(16'h0503, "R7 resident run untouched");
        expect_miss(16'h0620, "R7 no allocation while off");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_hits();
        t_lru();
        t_offset();
        t_disable();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule